// File: doc/BRIEF.md
# Cost-Aware Adaptive Output Port Selector

This block decides which output of a five-port mesh router (north, east, south, west and the local core) an arriving flit header should take. Each of the four neighbours reports the cost of entering it on a dedicated cost bus with an update strobe. The block holds those costs and keeps a small least-cost table. The table covers every node within two hops in x and in y of the router, and each entry records the best exit port for that destination. Entries are recomputed in distance-vector style: the cost through a neighbour is that neighbour's reported link cost plus a fixed per-hop charge for the remaining distance from it. A detour that is not minimal can therefore win when the direct link is congested.

For destinations beyond that local window, the block falls back to a greedy rule. It picks the cheapest direction that reduces the distance, using the currently held link costs. A request for the router's own coordinates always goes to the local port. A direction that would leave the mesh is never granted. The router's coordinates are static straps: they are sampled when the table is rebuilt after reset and on every cost update.

The grant is combinational from the request and the registered table. A cost update therefore changes lookups from the cycle after its strobe.

Top module: `mesh_port_selector`

## Requirements
- R1: While `req_vld` is low, `grant` is all zero. While it is high, `grant` has exactly one bit set in the same cycle.
- R2: A request whose destination equals (`my_x`, `my_y`) is granted the local port, bit 4 of `grant`.
- R3: Grant bit and cost slot order: index 0 is north (y+1), 1 is east (x+1), 2 is south (y-1), 3 is west (x-1), and `grant` bit 4 is local. `link_cost_in` slot i and `link_cost_stb` bit i belong to direction i.
- R4: For a destination at offset (dx, dy) with |dx|<=2, |dy|<=2 and not both zero, the grant goes to the on-mesh direction p that minimises cost[p] + HOP_COST × (Manhattan distance from neighbour p to the destination). This may be a direction that increases the distance.
- R5: When candidates have equal cost, the order north, east, south, west decides, with the earliest winning. This applies both to table entries and to the greedy fallback.
- R6: For a destination outside the two-hop window, the grant goes to the direction with the lowest held link cost among those that reduce |dx| or |dy|.
- R7: A direction that leads off the mesh edge is never granted: north when `my_y` = MESH_Y-1, south when `my_y` = 0, east when `my_x` = MESH_X-1, west when `my_x` = 0.
- R8: A strobe on `link_cost_stb[i]` stores `link_cost_in[i]` at the clock edge. Lookups in the strobe cycle still use the old table, and lookups from the next cycle use the new cost. Costs with no strobe keep their values.
- R9: After reset all held costs are zero, so every lookup picks the first distance-reducing direction in north, east, south, west order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_x | input | CW | Router x coordinate (static) |
| my_y | input | CW | Router y coordinate (static) |
| link_cost_in | input | 4×COST_W | Neighbour link costs, slot order N, E, S, W |
| link_cost_stb | input | 4 | Per-slot update strobes |
| req_vld | input | 1 | Header lookup request |
| req_x | input | CW | Destination x |
| req_y | input | CW | Destination y |
| grant | output | 5 | One-hot port grant: N, E, S, W, local |

## Verification
On every cycle, the assertions check the following: the grant is one-hot or idle as `req_vld` demands, a self-addressed request gets the local port, and no off-mesh direction is granted. They also check that a fallback grant always reduces distance, and that held costs follow their strobes and otherwise stay unchanged. Only the directed scenarios can show that the chosen port is the cheapest one, including cases where a non-minimal detour beats a congested direct link. The same holds for the tie order, the edge masking against cheap but illegal directions, and the one-cycle delay between a cost strobe and its effect on lookups.

// File: rtl/msel_pkg.sv
package msel_pkg;
  localparam int NUM_DIR = 4;
  localparam int P_N = 0;
  localparam int P_E = 1;
  localparam int P_S = 2;
  localparam int P_W = 3;
  localparam int P_L = 4;

  typedef logic [2:0] port_t;

  function automatic int dir_dx(int p);
    return (p == P_E) ? 1 : ((p == P_W) ? -1 : 0);
  endfunction

  function automatic int dir_dy(int p);
    return (p == P_N) ? 1 : ((p == P_S) ? -1 : 0);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction
endpackage

// File: rtl/msel_cost_bank.sv
module msel_cost_bank
  import msel_pkg::*;
#(
  parameter int COST_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_DIR-1:0][COST_W-1:0]    cost_in,
  input  logic [NUM_DIR-1:0]                cost_stb,
  output logic [NUM_DIR-1:0][COST_W-1:0]    cost_d,
  output logic [NUM_DIR-1:0][COST_W-1:0]    cost_q
);
  always_comb begin
    for (int i = 0; i < NUM_DIR; i++) begin
      cost_d[i] = cost_stb[i] ? cost_in[i] : cost_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q <= '0;
    end else begin
      cost_q <= cost_d;
    end
  end

  for (genvar gi = 0; gi < NUM_DIR; gi++) begin : g_chk
    // R8: a strobed cost is held from the next edge on
    p_cost_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cost_stb[gi] |=> cost_q[gi] == $past(cost_in[gi]));
    // R8: an unstrobed cost keeps its value
    p_cost_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cost_stb[gi] |=> $stable(cost_q[gi]));
  end
endmodule

// File: rtl/msel_subnet_table.sv
module msel_subnet_table
  import msel_pkg::*;
#(
  parameter int MESH_X   = 8,
  parameter int MESH_Y   = 8,
  parameter int CW       = 3,
  parameter int COST_W   = 4,
  parameter int SUB_R    = 2,
  parameter int HOP_COST = 2,
  localparam int SUB_D   = 2 * SUB_R + 1,
  localparam int NE      = SUB_D * SUB_D,
  localparam int ACC_W   = COST_W + $clog2(HOP_COST * (2 * SUB_D) + 1) + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CW-1:0]                  my_x,
  input  logic [CW-1:0]                  my_y,
  input  logic [NUM_DIR-1:0][COST_W-1:0] cost_d,
  input  logic                           build_en,
  output port_t [NE-1:0]                 entry_q
);
  logic [NUM_DIR-1:0] dir_ok;
  port_t [NE-1:0]     entry_d;

  always_comb begin
    dir_ok[P_N] = (my_y != CW'(MESH_Y - 1));
    dir_ok[P_E] = (my_x != CW'(MESH_X - 1));
    dir_ok[P_S] = (my_y != '0);
    dir_ok[P_W] = (my_x != '0);
  end

  for (genvar gx = 0; gx < SUB_D; gx++) begin : g_x
    for (genvar gy = 0; gy < SUB_D; gy++) begin : g_y
      localparam int OX  = gx - SUB_R;
      localparam int OY  = gy - SUB_R;
      localparam int IDX = gx * SUB_D + gy;
      if (OX == 0 && OY == 0) begin : g_self
        assign entry_d[IDX] = port_t'(P_L);
      end else begin : g_ent
        logic [ACC_W-1:0] best_c;
        logic [ACC_W-1:0] cand_c;
        logic             found;
        always_comb begin
          entry_d[IDX] = port_t'(P_L);
          best_c = '1;
          cand_c = '1;
          found  = 1'b0;
          for (int p = 0; p < NUM_DIR; p++) begin
            cand_c = ACC_W'(cost_d[p]) +
                     ACC_W'(HOP_COST * (iabs(OX - dir_dx(p)) + iabs(OY - dir_dy(p))));
            if (dir_ok[p] && (!found || cand_c < best_c)) begin
              best_c       = cand_c;
              entry_d[IDX] = port_t'(p);
              found        = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
    end else if (build_en) begin
      entry_q <= entry_d;
    end
  end
endmodule

// File: rtl/msel_port_pick.sv
module msel_port_pick
  import msel_pkg::*;
#(
  parameter int CW      = 3,
  parameter int COST_W  = 4,
  parameter int SUB_R   = 2,
  localparam int SUB_D  = 2 * SUB_R + 1,
  localparam int NE     = SUB_D * SUB_D,
  localparam int IDX_W  = $clog2(NE)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CW-1:0]                  my_x,
  input  logic [CW-1:0]                  my_y,
  input  logic                           req_vld,
  input  logic [CW-1:0]                  req_x,
  input  logic [CW-1:0]                  req_y,
  input  logic                           primed,
  input  logic [NUM_DIR-1:0][COST_W-1:0] cost_q,
  input  port_t [NE-1:0]                 entry_q,
  output logic [NUM_DIR:0]               grant
);
  logic signed [CW:0] dxs, dys;
  int                 dx, dy;
  logic               in_sub;
  logic [NUM_DIR-1:0] prod;
  logic [IDX_W-1:0]   idx;
  logic [COST_W-1:0]  best_c;
  logic               found;
  logic [NUM_DIR-1:0] greedy;

  always_comb begin
    dxs    = $signed({1'b0, req_x}) - $signed({1'b0, my_x});
    dys    = $signed({1'b0, req_y}) - $signed({1'b0, my_y});
    dx     = int'(dxs);
    dy     = int'(dys);
    in_sub = (iabs(dx) <= SUB_R) && (iabs(dy) <= SUB_R);
    idx    = IDX_W'((dx + SUB_R) * SUB_D + (dy + SUB_R));
    prod[P_N] = (dy > 0);
    prod[P_E] = (dx > 0);
    prod[P_S] = (dy < 0);
    prod[P_W] = (dx < 0);
  end

  always_comb begin
    greedy = '0;
    best_c = '1;
    found  = 1'b0;
    for (int p = 0; p < NUM_DIR; p++) begin
      if (prod[p] && (!found || cost_q[p] < best_c)) begin
        best_c = cost_q[p];
        greedy = NUM_DIR'(1) << p;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    if (!req_vld) begin
      grant = '0;
    end else if (dx == 0 && dy == 0) begin
      grant = (NUM_DIR + 1)'(1) << P_L;
    end else if (primed && in_sub) begin
      grant = (NUM_DIR + 1)'(1) << entry_q[idx];
    end else begin
      grant = {1'b0, greedy};
    end
  end

  // R1: idle requests grant nothing, live ones exactly one port
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> grant == '0);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> $countones(grant) == 1);
  // R2: self-addressed flits leave on the local port
  p_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_x == my_x && req_y == my_y) |-> grant[P_L]);
  // R6: outside the window only distance-reducing directions are used
  p_productive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !in_sub) |-> (grant & ~{1'b0, prod}) == '0);
endmodule

// File: rtl/mesh_port_selector.sv
module mesh_port_selector
  import msel_pkg::*;
#(
  parameter int MESH_X   = 8,
  parameter int MESH_Y   = 8,
  parameter int CW       = 3,
  parameter int COST_W   = 4,
  parameter int SUB_R    = 2,
  parameter int HOP_COST = 2,
  localparam int NE      = (2 * SUB_R + 1) * (2 * SUB_R + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CW-1:0]                     my_x,
  input  logic [CW-1:0]                     my_y,
  input  logic [NUM_DIR-1:0][COST_W-1:0]    link_cost_in,
  input  logic [NUM_DIR-1:0]                link_cost_stb,
  input  logic                              req_vld,
  input  logic [CW-1:0]                     req_x,
  input  logic [CW-1:0]                     req_y,
  output logic [NUM_DIR:0]                  grant
);
  logic                           rst_meta, rst_sync_n;
  logic                           primed_q;
  logic                           build_en;
  logic [NUM_DIR-1:0][COST_W-1:0] cost_d, cost_q;
  port_t [NE-1:0]                 entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      primed_q <= 1'b0;
    end else begin
      primed_q <= 1'b1;
    end
  end

  assign build_en = (|link_cost_stb) || !primed_q;

  msel_cost_bank #(.COST_W(COST_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cost_in  (link_cost_in),
    .cost_stb (link_cost_stb),
    .cost_d   (cost_d),
    .cost_q   (cost_q)
  );

  msel_subnet_table #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .CW(CW), .COST_W(COST_W),
    .SUB_R(SUB_R), .HOP_COST(HOP_COST)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .my_x     (my_x),
    .my_y     (my_y),
    .cost_d   (cost_d),
    .build_en (build_en),
    .entry_q  (entry_q)
  );

  msel_port_pick #(.CW(CW), .COST_W(COST_W), .SUB_R(SUB_R)) u_pick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .my_x    (my_x),
    .my_y    (my_y),
    .req_vld (req_vld),
    .req_x   (req_x),
    .req_y   (req_y),
    .primed  (primed_q),
    .cost_q  (cost_q),
    .entry_q (entry_q),
    .grant   (grant)
  );

  // R7: no grant toward a missing neighbour
  p_no_offedge_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !((grant[P_N] && my_y == CW'(MESH_Y - 1)) || (grant[P_S] && my_y == '0) ||
      (grant[P_E] && my_x == CW'(MESH_X - 1)) || (grant[P_W] && my_x == '0)));
endmodule

// File: tb/mesh_port_selector_bench.sv
module mesh_port_selector_bench;
  localparam int CLK_P  = 10;
  localparam int CW     = 3;
  localparam int COST_W = 4;

  localparam logic [4:0] G_N = 5'b00001;
  localparam logic [4:0] G_E = 5'b00010;
  localparam logic [4:0] G_S = 5'b00100;
  localparam logic [4:0] G_W = 5'b01000;
  localparam logic [4:0] G_L = 5'b10000;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [CW-1:0]           my_x, my_y;
  logic [3:0][COST_W-1:0]  link_cost_in;
  logic [3:0]              link_cost_stb;
  logic                    req_vld;
  logic [CW-1:0]           req_x, req_y;
  logic [4:0]              grant;
  int                      n_chk = 0;
  int                      n_bad = 0;
  bit                      done  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  mesh_port_selector u_mesh_port_selector (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .link_cost_in(link_cost_in), .link_cost_stb(link_cost_stb),
    .req_vld(req_vld), .req_x(req_x), .req_y(req_y), .grant(grant)
  );

  task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic do_reset(int x, int y);
    @(negedge clk);
    rst_n = 1'b0; my_x = CW'(x); my_y = CW'(y);
    link_cost_in = '0; link_cost_stb = '0; req_vld = 1'b0; req_x = '0; req_y = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_costs(int n, int e, int s, int w);
    @(negedge clk);
    req_vld = 1'b0;
    link_cost_in = {COST_W'(w), COST_W'(s), COST_W'(e), COST_W'(n)};
    link_cost_stb = 4'hF;
    @(negedge clk);
    link_cost_stb = '0;
  endtask

  task automatic look(string tag, int x, int y, logic [4:0] exp);
    @(negedge clk);
    req_vld = 1'b1; req_x = CW'(x); req_y = CW'(y);
    #1 chk(tag, grant, exp);
  endtask

  task automatic t_reset_state;
    do_reset(3, 3);
    #1 chk("R1 idle after reset", grant, 5'b0);
    look("R9 zero costs NE dest", 4, 4, G_N);
    look("R9 zero costs SW dest", 2, 2, G_S);
    look("R9 zero costs far SE dest", 6, 1, G_E);
    @(negedge clk) req_vld = 1'b0;
    #1 chk("R1 idle request", grant, 5'b0);
  endtask

  task automatic t_local;
    look("R2 own coordinates", 3, 3, G_L);
  endtask

  task automatic t_subnet_cost;
    set_costs(1, 15, 15, 15);
    look("R4 R3 detour north beats congested east", 4, 3, G_N);
    look("R4 detour north for south target", 3, 1, G_N);
    set_costs(3, 3, 3, 3);
    look("R4 minimal south", 3, 1, G_S);
  endtask

  task automatic t_ties;
    set_costs(5, 5, 5, 5);
    look("R5 N before E", 4, 4, G_N);
    look("R5 S before W", 2, 2, G_S);
    look("R5 fallback S before W", 0, 0, G_S);
    look("R5 fallback N before E", 7, 7, G_N);
  endtask

  task automatic t_outside;
    set_costs(1, 15, 15, 15);
    look("R6 only east reduces distance", 7, 3, G_E);
    look("R6 cheaper productive north", 6, 6, G_N);
    set_costs(15, 2, 9, 9);
    look("R6 cheaper productive east", 6, 6, G_E);
  endtask

  task automatic t_edges;
    do_reset(0, 0);
    set_costs(15, 15, 0, 0);
    look("R7 corner masks cheap S and W", 1, 0, G_E);
    do_reset(7, 7);
    set_costs(0, 0, 15, 15);
    look("R7 corner masks cheap N and E", 6, 7, G_W);
  endtask

  task automatic t_update_timing;
    do_reset(3, 3);
    set_costs(5, 5, 5, 5);
    look("R8 before update", 3, 5, G_N);
    @(negedge clk);
    link_cost_in[0] = COST_W'(15); link_cost_stb = 4'b0001;
    #1 chk("R8 strobe cycle keeps old entry", grant, G_N);
    @(negedge clk);
    link_cost_stb = '0;
    #1 chk("R8 next cycle uses new cost", grant, G_E);
    look("R8 other costs retained", 7, 7, G_E);
  endtask

  initial begin
    t_reset_state();
    t_local();
    t_subnet_cost();
    t_ties();
    t_outside();
    t_edges();
    t_update_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule